// File: doc/BRIEF.md
# SPI Controller Register and Interrupt Interface

This block is the memory-mapped front end of an SPI master. A simple register bus (write strobe, read strobe, byte address, 32-bit data) reaches configuration, enable, delay, idle-count and transmit-watermark registers. The same bus reaches a transmit-data port and a receive-data port. A write to the transmit-data port raises a one-cycle push strobe to the transmit FIFO. A read of the receive-data port returns the receive FIFO head and raises a one-cycle pop strobe. The FIFOs and the shifter live outside this block. The block sees the FIFO occupancy levels and a mode-fault event pulse.

Interrupts use four registers that share one 7-bit layout. The status register latches its sources, and software clears bits by writing 1s to it. Two write-only ports set or clear bits of a read-only mask. One interrupt line is asserted whenever a latched status bit is also enabled in the mask. Read data is combinational in the cycle of the read strobe. Writes take effect on the clock edge.

Top module: `spi_regif_top`

## Requirements
- R1: After reset, configuration reads the CFG_RESET parameter, watermark reads 1, enable reads 0, mask reads 0, and irq is low. Registers decode at byte offsets: configuration 0x00, status 0x04, mask-set 0x08, mask-clear 0x0C, mask 0x10, enable 0x14, delay 0x18, transmit data 0x1C, receive data 0x20, idle count 0x24, watermark 0x28.
- R2: Writing to 0x08 sets every mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R3: Writing to 0x0C clears every mask bit whose data bit is 1. The mask at 0x10 is read-only, so writes to it leave it unchanged.
- R4: Writing 1s to the status register at 0x04 clears those bits when their source is inactive. Bits written 0 are unaffected.
- R5: Status bit 1 (mode fault) is set by a one-cycle modeFault pulse and stays set until cleared. If the event and the clear arrive in the same cycle, the bit stays set.
- R6: Status bit 4 is set while rxLevel is non-zero. Status bit 3 is set while txLevel equals FIFO_DEPTH. A clear has no effect on either bit while its condition holds.
- R7: Status bit 2 is set while txLevel is strictly below the watermark register, which is read/write at 0x28. A level equal to the watermark does not set it.
- R8: irq is high exactly when some status bit and the same mask bit are both 1.
- R9: A write to 0x1C pulses txPush in that cycle with txData equal to the low byte of the write data.
- R10: A read of 0x20 returns rxData zero-extended and pulses rxPop in that cycle. A read of any other offset leaves rxPop low.
- R11: Configuration (32 bits), enable (bit 0), delay (32 bits) and idle count (8 bits) read back what was written, truncated to their widths, and drive cfgWord, ctrlEnable, delayWord and idleCount.
- R12: Reads of 0x08, 0x0C, 0x1C and of unmapped offsets return 0. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data, valid while busRdEn is high |
| txPush | output | 1 | Transmit FIFO push strobe |
| txData | output | 8 | Byte pushed into the transmit FIFO |
| txLevel | input | LEVEL_W | Transmit FIFO occupancy |
| rxPop | output | 1 | Receive FIFO pop strobe |
| rxData | input | 8 | Receive FIFO head byte |
| rxLevel | input | LEVEL_W | Receive FIFO occupancy |
| modeFault | input | 1 | One-cycle mode-fault event |
| irq | output | 1 | Interrupt request |
| cfgWord | output | DATA_W | Configuration register contents |
| ctrlEnable | output | 1 | Controller enable |
| delayWord | output | DATA_W | Delay register contents |
| idleCount | output | 8 | Idle count register contents |

## Verification
The bench builds the block with FIFO_DEPTH of 8, which gives a 4-bit level. This lets the full condition and both sides of a raised watermark of 4 be driven directly as small FIFO levels. CFG_RESET is set to a non-zero pattern, so the reset check can tell a loaded reset value from an all-zero register. Because the levels are free inputs, the bench can clear a status bit while its condition holds and again after the condition drops. It can also line up a mode-fault pulse with a clear in the same cycle.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;
  // Byte offsets of the register window
  localparam int OFF_CFG = 'h00;
  localparam int OFF_ISR = 'h04;
  localparam int OFF_IER = 'h08;
  localparam int OFF_IDR = 'h0C;
  localparam int OFF_IMR = 'h10;
  localparam int OFF_ENA = 'h14;
  localparam int OFF_DLY = 'h18;
  localparam int OFF_TXD = 'h1C;
  localparam int OFF_RXD = 'h20;
  localparam int OFF_IDL = 'h24;
  localparam int OFF_THR = 'h28;

  // Interrupt bit layout shared by status, mask-set, mask-clear and mask
  localparam int IRQ_W      = 7;
  localparam int BIT_MODF   = 1;
  localparam int BIT_TXLOW  = 2;
  localparam int BIT_TXFULL = 3;
  localparam int BIT_RXNE   = 4;

  localparam int BYTE_W = 8;
  localparam int IDLE_W = 8;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CFG, SEL_ISR, SEL_IMR, SEL_ENA,
    SEL_DLY, SEL_RXD, SEL_IDL, SEL_THR
  } rdSel_e;

  typedef struct packed {
    logic   wrCfg;
    logic   wrIsr;
    logic   wrIer;
    logic   wrIdr;
    logic   wrEna;
    logic   wrDly;
    logic   wrTxd;
    logic   wrIdl;
    logic   wrThr;
    logic   rdRxd;
    logic   rdEn;
    rdSel_e rdSel;
  } regStrobe_t;
endpackage

// File: rtl/spi_regif_ctrl.sv
module spi_regif_ctrl
  import spi_regif_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strobe
);
  always_comb begin
    strobe       = '0;
    strobe.rdSel = SEL_NONE;
    strobe.rdEn  = busRdEn;
    case (busAddr)
      ADDR_W'(OFF_CFG): begin strobe.wrCfg = busWrEn; strobe.rdSel = SEL_CFG; end
      ADDR_W'(OFF_ISR): begin strobe.wrIsr = busWrEn; strobe.rdSel = SEL_ISR; end
      ADDR_W'(OFF_IER): strobe.wrIer = busWrEn;
      ADDR_W'(OFF_IDR): strobe.wrIdr = busWrEn;
      ADDR_W'(OFF_IMR): strobe.rdSel = SEL_IMR;
      ADDR_W'(OFF_ENA): begin strobe.wrEna = busWrEn; strobe.rdSel = SEL_ENA; end
      ADDR_W'(OFF_DLY): begin strobe.wrDly = busWrEn; strobe.rdSel = SEL_DLY; end
      ADDR_W'(OFF_TXD): strobe.wrTxd = busWrEn;
      ADDR_W'(OFF_RXD): begin strobe.rdRxd = busRdEn; strobe.rdSel = SEL_RXD; end
      ADDR_W'(OFF_IDL): begin strobe.wrIdl = busWrEn; strobe.rdSel = SEL_IDL; end
      ADDR_W'(OFF_THR): begin strobe.wrThr = busWrEn; strobe.rdSel = SEL_THR; end
      default: ;
    endcase
  end
endmodule

// File: rtl/spi_regif_dp.sv
module spi_regif_dp
  import spi_regif_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          FIFO_DEPTH = 128,
  parameter int          LEVEL_W    = 8,
  parameter logic [31:0] CFG_RESET  = 32'h0
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strobe,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  output logic               txPush,
  output logic [BYTE_W-1:0]  txData,
  input  logic [LEVEL_W-1:0] txLevel,
  output logic               rxPop,
  input  logic [BYTE_W-1:0]  rxData,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic               modeFault,
  output logic               irq,
  output logic [DATA_W-1:0]  cfgWord,
  output logic               ctrlEnable,
  output logic [DATA_W-1:0]  delayWord,
  output logic [IDLE_W-1:0]  idleCount,
  output logic [IRQ_W-1:0]   statusBits,
  output logic [IRQ_W-1:0]   maskBits
);
  localparam logic [LEVEL_W-1:0] FULL_LVL = LEVEL_W'(FIFO_DEPTH);

  logic [DATA_W-1:0]  cfgQ, dlyQ;
  logic               enaQ;
  logic [IDLE_W-1:0]  idlQ;
  logic [LEVEL_W-1:0] thrQ;
  logic [IRQ_W-1:0]   maskQ, statusQ, srcVec, clrVec;

  // Interrupt sources: one event latch and three level conditions
  always_comb begin
    srcVec             = '0;
    srcVec[BIT_MODF]   = modeFault;
    srcVec[BIT_TXLOW]  = txLevel < thrQ;
    srcVec[BIT_TXFULL] = txLevel == FULL_LVL;
    srcVec[BIT_RXNE]   = rxLevel != '0;
    clrVec             = strobe.wrIsr ? busWrData[IRQ_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= CFG_RESET[DATA_W-1:0];
      dlyQ    <= '0;
      enaQ    <= 1'b0;
      idlQ    <= '0;
      thrQ    <= LEVEL_W'(1);
      maskQ   <= '0;
      statusQ <= '0;
    end else begin
      if (strobe.wrCfg) cfgQ <= busWrData;
      if (strobe.wrDly) dlyQ <= busWrData;
      if (strobe.wrEna) enaQ <= busWrData[0];
      if (strobe.wrIdl) idlQ <= busWrData[IDLE_W-1:0];
      if (strobe.wrThr) thrQ <= busWrData[LEVEL_W-1:0];
      if (strobe.wrIer)      maskQ <= maskQ | busWrData[IRQ_W-1:0];
      else if (strobe.wrIdr) maskQ <= maskQ & ~busWrData[IRQ_W-1:0];
      // a source active in the clearing cycle wins over the clear
      statusQ <= (statusQ & ~clrVec) | srcVec;
    end
  end

  always_comb begin
    busRdData = '0;
    if (strobe.rdEn) begin
      case (strobe.rdSel)
        SEL_CFG: busRdData = cfgQ;
        SEL_ISR: busRdData = DATA_W'(statusQ);
        SEL_IMR: busRdData = DATA_W'(maskQ);
        SEL_ENA: busRdData = DATA_W'(enaQ);
        SEL_DLY: busRdData = dlyQ;
        SEL_RXD: busRdData = DATA_W'(rxData);
        SEL_IDL: busRdData = DATA_W'(idlQ);
        SEL_THR: busRdData = DATA_W'(thrQ);
        default: busRdData = '0;
      endcase
    end
  end

  assign txPush     = strobe.wrTxd;
  assign txData     = busWrData[BYTE_W-1:0];
  assign rxPop      = strobe.rdRxd;
  assign irq        = |(statusQ & maskQ);
  assign cfgWord    = cfgQ;
  assign ctrlEnable = enaQ;
  assign delayWord  = dlyQ;
  assign idleCount  = idlQ;
  assign statusBits = statusQ;
  assign maskBits   = maskQ;
endmodule

// File: rtl/spi_regif_top.sv
module spi_regif_top
  import spi_regif_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 32,
  parameter int          FIFO_DEPTH = 128,
  parameter logic [31:0] CFG_RESET  = 32'h0000_0008,
  localparam int         LEVEL_W    = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  output logic               txPush,
  output logic [7:0]         txData,
  input  logic [LEVEL_W-1:0] txLevel,
  output logic               rxPop,
  input  logic [7:0]         rxData,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic               modeFault,
  output logic               irq,
  output logic [DATA_W-1:0]  cfgWord,
  output logic               ctrlEnable,
  output logic [DATA_W-1:0]  delayWord,
  output logic [7:0]         idleCount
);
  regStrobe_t       strobe;
  logic [IRQ_W-1:0] statusBits, maskBits;

  spi_regif_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr), .strobe(strobe)
  );

  spi_regif_dp #(
    .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .LEVEL_W(LEVEL_W), .CFG_RESET(CFG_RESET)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWrData(busWrData),
    .busRdData(busRdData), .txPush(txPush), .txData(txData), .txLevel(txLevel),
    .rxPop(rxPop), .rxData(rxData), .rxLevel(rxLevel), .modeFault(modeFault),
    .irq(irq), .cfgWord(cfgWord), .ctrlEnable(ctrlEnable), .delayWord(delayWord),
    .idleCount(idleCount), .statusBits(statusBits), .maskBits(maskBits)
  );
endmodule

// File: rtl/spi_regif_chk.sv
module spi_regif_chk
  import spi_regif_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LEVEL_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               busWrEn,
  input logic               busRdEn,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [BYTE_W-1:0]  wrByte,
  input logic               txPush,
  input logic [BYTE_W-1:0]  txData,
  input logic               rxPop,
  input logic [LEVEL_W-1:0] rxLevel,
  input logic               modeFault,
  input logic               irq,
  input logic [IRQ_W-1:0]   statusBits,
  input logic [IRQ_W-1:0]   maskBits
);
  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(OFF_IER)) |=>
      ((maskBits & $past(wrByte[IRQ_W-1:0])) == $past(wrByte[IRQ_W-1:0])));
  // R3
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(OFF_IDR)) |=>
      ((maskBits & $past(wrByte[IRQ_W-1:0])) == '0));
  // R3
  mask_ro_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(OFF_IMR)) |=> $stable(maskBits));
  // R5
  modf_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeFault |=> statusBits[BIT_MODF]);
  // R6
  rx_ne_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel != '0) |=> statusBits[BIT_RXNE]);
  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskBits == '0) |-> !irq);
  // R9
  tx_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    txPush |-> (busWrEn && busAddr == ADDR_W'(OFF_TXD) && txData == wrByte));
  // R10
  rx_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |-> (busRdEn && busAddr == ADDR_W'(OFF_RXD)));
endmodule

bind spi_regif_top spi_regif_chk #(.ADDR_W(ADDR_W), .LEVEL_W(LEVEL_W)) chk_i (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
  .wrByte(busWrData[7:0]), .txPush(txPush), .txData(txData), .rxPop(rxPop),
  .rxLevel(rxLevel), .modeFault(modeFault), .irq(irq), .statusBits(statusBits),
  .maskBits(maskBits)
);

// File: tb/spi_regif_top_tb_top.sv
module spi_regif_top_tb_top;
  import spi_regif_pkg::*;

  localparam int          CLK_PERIOD = 10;
  localparam int          DEPTH      = 8;
  localparam int          LW         = $clog2(DEPTH + 1);
  localparam int          AW         = 8;
  localparam int          DW         = 32;
  localparam logic [31:0] CFG_RST    = 32'h0000_4C09;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busWrEn = 1'b0, busRdEn = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWrData = '0;
  logic [DW-1:0] busRdData;
  logic          txPush, rxPop, irq, ctrlEnable;
  logic [7:0]    txData, idleCount;
  logic [7:0]    rxData = '0;
  logic [LW-1:0] txLevel = LW'(2), rxLevel = '0;
  logic          modeFault = 1'b0;
  logic [DW-1:0] cfgWord, delayWord;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_regif_top #(.ADDR_W(AW), .DATA_W(DW), .FIFO_DEPTH(DEPTH), .CFG_RESET(CFG_RST)) dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .txPush(txPush), .txData(txData),
    .txLevel(txLevel), .rxPop(rxPop), .rxData(rxData), .rxLevel(rxLevel),
    .modeFault(modeFault), .irq(irq), .cfgWord(cfgWord), .ctrlEnable(ctrlEnable),
    .delayWord(delayWord), .idleCount(idleCount)
  );

  typedef struct {
    logic [DW-1:0] val;
    logic [AW-1:0] addr;
    string         tag;
  } rdItem_t;

  rdItem_t expQ[$];
  int      checks = 0;
  int      fails = 0;
  bit      done = 1'b0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares read data and the pop strobe mid-cycle
  always @(negedge clk) begin
    if (busRdEn) begin
      if (expQ.size() == 0) begin
        chk("scoreboard underflow", 32'd1, 32'd0);
      end else begin
        rdItem_t item;
        item = expQ.pop_front();
        chk(item.tag, busRdData, item.val);
        chk({item.tag, " pop strobe R10"}, DW'(rxPop), DW'(item.addr == AW'(OFF_RXD)));
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input int addr, input logic [DW-1:0] data);
    busWrEn = 1'b1; busAddr = AW'(addr); busWrData = data;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic rd(input int addr, input logic [DW-1:0] exp, input string tag);
    expQ.push_back('{val: exp, addr: AW'(addr), tag: tag});
    busRdEn = 1'b1; busAddr = AW'(addr);
    @(posedge clk); #1;
    busRdEn = 1'b0;
  endtask

  task automatic wrTx(input logic [DW-1:0] data);
    busWrEn = 1'b1; busAddr = AW'(OFF_TXD); busWrData = data;
    @(negedge clk);
    chk("R9 push strobe", DW'(txPush), 32'd1);
    chk("R9 push byte", DW'(txData), DW'(data[7:0]));
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    rd(OFF_CFG, CFG_RST, "R1 cfg reset");
    rd(OFF_THR, 32'd1, "R1 watermark reset");
    rd(OFF_IMR, 32'd0, "R1 mask reset");
    rd(OFF_ENA, 32'd0, "R1 enable reset");
    rd(OFF_ISR, 32'd0, "R1 status idle");
    chk("R1 irq reset", DW'(irq), 32'd0);
    // R11 plain registers
    wr(OFF_CFG, 32'h1234_5678);
    chk("R11 cfgWord", cfgWord, 32'h1234_5678);
    rd(OFF_CFG, 32'h1234_5678, "R11 cfg readback");
    wr(OFF_ENA, 32'hFFFF_FFFF);
    chk("R11 ctrlEnable", DW'(ctrlEnable), 32'd1);
    rd(OFF_ENA, 32'd1, "R11 enable readback");
    wr(OFF_DLY, 32'hA5A5_5A5A);
    chk("R11 delayWord", delayWord, 32'hA5A5_5A5A);
    rd(OFF_DLY, 32'hA5A5_5A5A, "R11 delay readback");
    wr(OFF_IDL, 32'h0000_01FF);
    chk("R11 idleCount", DW'(idleCount), 32'hFF);
    rd(OFF_IDL, 32'hFF, "R11 idle readback");
    // R9 transmit push, write-only reads zero
    wrTx(32'h0000_ABCD);
    rd(OFF_TXD, 32'd0, "R12 txd reads zero");
    // R10 receive pop and R6 not-empty
    rxData = 8'h5A; rxLevel = LW'(3);
    idle(1);
    rd(OFF_RXD, 32'h5A, "R10 rx data");
    rd(OFF_ISR, 32'h10, "R6 rx not empty");
    chk("R8 irq masked off", DW'(irq), 32'd0);
    // R2 mask set and R8 irq
    wr(OFF_IER, 32'h10);
    rd(OFF_IMR, 32'h10, "R2 mask set");
    chk("R8 irq enabled", DW'(irq), 32'd1);
    wr(OFF_ISR, 32'h10);
    rd(OFF_ISR, 32'h10, "R6 clear while held");
    rxLevel = '0;
    idle(1);
    wr(OFF_ISR, 32'h10);
    rd(OFF_ISR, 32'h0, "R4 w1c clears");
    chk("R8 irq after clear", DW'(irq), 32'd0);
    wr(OFF_IER, 32'h21);
    rd(OFF_IMR, 32'h31, "R2 zeros keep bits");
    wr(OFF_IER, 32'h7F);
    wr(OFF_IDR, 32'h05);
    rd(OFF_IMR, 32'h7A, "R3 mask clear");
    wr(OFF_IMR, 32'h0);
    rd(OFF_IMR, 32'h7A, "R3 mask read-only");
    rd(OFF_IER, 32'd0, "R12 mask-set reads zero");
    rd(OFF_IDR, 32'd0, "R12 mask-clear reads zero");
    // R5 mode fault latch
    modeFault = 1'b1; idle(1); modeFault = 1'b0;
    idle(3);
    rd(OFF_ISR, 32'h02, "R5 fault latched");
    chk("R8 irq on fault", DW'(irq), 32'd1);
    wr(OFF_ISR, 32'h02);
    rd(OFF_ISR, 32'h0, "R5 fault cleared");
    modeFault = 1'b1;
    wr(OFF_ISR, 32'h02);
    modeFault = 1'b0;
    rd(OFF_ISR, 32'h02, "R5 event beats clear");
    wr(OFF_ISR, 32'h02);
    // R7 watermark
    wr(OFF_THR, 32'd4);
    rd(OFF_THR, 32'd4, "R7 watermark readback");
    rd(OFF_ISR, 32'h04, "R7 level below watermark");
    chk("R8 irq bit2 masked", DW'(irq), 32'd0);
    txLevel = LW'(4);
    wr(OFF_ISR, 32'h04);
    rd(OFF_ISR, 32'h0, "R7 level at watermark");
    txLevel = LW'(DEPTH);
    idle(1);
    rd(OFF_ISR, 32'h08, "R6 tx full");
    chk("R8 irq on full", DW'(irq), 32'd1);
    wr(OFF_ISR, 32'h08);
    rd(OFF_ISR, 32'h08, "R6 full held after clear");
    txLevel = LW'(3);
    idle(1);
    rd(OFF_ISR, 32'h0C, "R7 below watermark again");
    // R12 unmapped
    wr('h30, 32'hFFFF_FFFF);
    rd('h30, 32'd0, "R12 unmapped reads zero");
    rd(OFF_CFG, 32'h1234_5678, "R12 unmapped write ignored");
    rd(OFF_DLY, 32'hA5A5_5A5A, "R12 delay untouched");
    idle(2);
    if (expQ.size() != 0) chk("scoreboard leftover", DW'(expQ.size()), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule